// File: doc/BRIEF.md
# Low-Power Clock Enable Controller

This block decides, cycle by cycle, which clocks of a small microcontroller may run. Four status bits from the CPU select a low-power level: a CPU stop bit, a fast-oscillator stop bit, a subsystem-clock stop bit and a crystal stop bit. The block combines them with an interrupt-in-service flag and a debug-enable input. From these it produces enables for the core clock, the subsystem clock, the auxiliary clock, the fast oscillator and the low-frequency crystal, plus a CPU-halt flag. The clocks are modelled as synchronous enables of a single reference clock, so any gating cell placed downstream sees enables that come straight from flops.

The five usual levels are set by these bit combinations (cpu, fast, sub, xtal): level 0 = 1000, level 1 = 1100, level 2 = 1010, level 3 = 1110 and level 4 = 1111. The CPU sets the bits. An accepted interrupt raises the in-service flag, and that flag brings every clock back until the routine returns. If the routine leaves the bits set, the same level is entered again. Asynchronous wake-up pins pass through a multi-stage synchronizer that advances on core-clock cycles, and the synchronizer output drives the interrupt request lines.

Top module: `lpm_clk_gate`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all status state is clear: every enable is 1, cpu_halt is 0 and wake_irq is all zeros.
- R2: Every control input (status bits, isr_active, dbg_en) is captured at a clock edge. Enables and cpu_halt reflect it from that edge on, not earlier.
- R3: With the CPU stop bit set and neither isr nor debug active, core_clk_en is 0 and cpu_halt is 1. With the CPU stop bit clear, core_clk_en is 1 and cpu_halt is 0.
- R4: fast_osc_en is 0 exactly when the fast-oscillator stop bit is set and neither isr nor debug is active (levels 1, 3 and 4).
- R5: When SUB_GATE_EN=1, sub_clk_en is 0 while the subsystem stop bit is set and isr is inactive. When SUB_GATE_EN=0, sub_clk_en is always 1.
- R6: When XTAL_OFF_EN=1, xtal_en is 0 while the crystal stop bit is set and isr is inactive. aux_clk_en is gated the same way only when both AUX_DIV_EN and XTAL_OFF_EN are 1. Otherwise each stays 1.
- R7: While dbg_en is captured as 1, core_clk_en and fast_osc_en stay 1 in every level, and cpu_halt still follows the CPU stop bit.
- R8: While isr_active is captured as 1, all five enables are 1 and cpu_halt is 0, whatever the status bits are.
- R9: When isr_active drops and the status bits are still set, the previous level's gating returns on the next edge. If the bits were cleared during service, the block stays fully active.
- R10: A wake pin held high appears on its wake_irq bit after SYNC_DEPTH core-clock-enabled edges, and falls the same way.
- R11: With SYNC_ON_CORE=1, the synchronizer stages hold their value on edges where the captured core clock is disabled. A pin raised while the core is stopped stays invisible until the core clock runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from which all gated clocks are derived |
| rst_n | input | 1 | Synchronous active-low power-up clear |
| cpu_off_bit | input | 1 | Status bit: stop the CPU and its core clock |
| fast_osc_off_bit | input | 1 | Status bit: stop the fast internal oscillator |
| sub_clk_off_bit | input | 1 | Status bit: stop the subsystem clock |
| xtal_off_bit | input | 1 | Status bit: stop the low-frequency crystal |
| isr_active | input | 1 | High from interrupt acceptance until return |
| dbg_en | input | 1 | Debug interface enabled; keeps core clock and fast oscillator alive |
| wake_pin | input | N_WAKE | Asynchronous wake-up inputs |
| fast_osc_en | output | 1 | Fast oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| sub_clk_en | output | 1 | Subsystem clock enable |
| aux_clk_en | output | 1 | Auxiliary clock enable |
| xtal_en | output | 1 | Low-frequency crystal enable |
| cpu_halt | output | 1 | CPU executes no instructions |
| wake_irq | output | N_WAKE | Synchronized wake-up interrupt requests |

## Verification
The hardest situation to reach is a wake pin that rises while the core clock is stopped. Here the synchronizer must freeze, and it must release only when an interrupt or a status change restarts the core clock. The stimulus parks the block in level 0 with debug off and holds a pin high for several cycles while the request line stays low. It then raises isr_active, and the request appears two enabled edges later. A second instance built with every gating option off and a free-running synchronizer sees the same stimulus, so both variants of the enable logic are compared against the reference model in every cycle.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power clock enable controller.
package lpm_pkg;

    // Captured control state; every field is a flop.
    typedef struct packed {
        logic cpu_off;
        logic fast_off;
        logic sub_off;
        logic xtal_off;
        logic isr;
        logic dbg;
    } lpm_state_t;

    // Enables and halt flag produced from the captured state.
    typedef struct packed {
        logic fast_osc;
        logic core;
        logic sub;
        logic aux;
        logic xtal;
        logic halt;
    } lpm_en_t;

endpackage

// File: rtl/lpm_state_reg.sv
// Capture register for the control inputs.
// Assumes: inputs are synchronous to clk; rst_n is a synchronous active-low clear.
module lpm_state_reg
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_state_t nxt,
    output lpm_state_t cur
);

    // Capture the control inputs on each edge; clear to the active level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

endmodule

// File: rtl/lpm_enable_logic.sv
// Combinational decode of the captured state into clock enables.
// Assumes: st comes straight from flops, so the enables cannot glitch.
// The build options pick between gated and always-on variants.
module lpm_enable_logic
    import lpm_pkg::*;
#(
    parameter bit SUB_GATE_EN = 1'b1,
    parameter bit AUX_DIV_EN  = 1'b1,
    parameter bit XTAL_OFF_EN = 1'b1
) (
    input  lpm_state_t st,
    output lpm_en_t    en
);

    localparam bit AUX_GATE = AUX_DIV_EN && XTAL_OFF_EN;

    logic keep_fast;
    logic sub_on;
    logic aux_on;
    logic xtal_on;

    // Core-side enables: interrupt service or debug keeps the core fed.
    always_comb begin
        keep_fast   = st.isr | st.dbg;
        en.halt     = st.cpu_off & ~st.isr;
        en.core     = keep_fast | ~st.cpu_off;
        en.fast_osc = keep_fast | ~st.fast_off;
        en.sub      = sub_on;
        en.aux      = aux_on;
        en.xtal     = xtal_on;
    end

    generate
        if (SUB_GATE_EN) begin : g_sub_gated
            // Subsystem clock stops on its bit unless an interrupt is in service.
            always_comb sub_on = st.isr | ~st.sub_off;
        end else begin : g_sub_free
            // Gating option absent: subsystem clock always runs.
            always_comb sub_on = 1'b1;
        end

        if (XTAL_OFF_EN) begin : g_xtal_gated
            // Crystal stops on its bit unless an interrupt is in service.
            always_comb xtal_on = st.isr | ~st.xtal_off;
        end else begin : g_xtal_free
            // Crystal stop option absent.
            always_comb xtal_on = 1'b1;
        end

        if (AUX_GATE) begin : g_aux_gated
            // Auxiliary clock follows the crystal when it is divided from it.
            always_comb aux_on = st.isr | ~st.xtal_off;
        end else begin : g_aux_free
            // Auxiliary clock never stops in this build.
            always_comb aux_on = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/lpm_wake_sync.sv
// Multi-stage synchronizer that turns asynchronous wake pins into interrupt requests.
// Assumes: pins are held until the interrupt is taken. With SYNC_ON_CORE=1 the
// stages advance only on edges where the core clock is enabled.
module lpm_wake_sync #(
    parameter int N_WAKE       = 2,
    parameter int SYNC_DEPTH   = 2,
    parameter bit SYNC_ON_CORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic [N_WAKE-1:0] pin,
    output logic [N_WAKE-1:0] irq
);

    localparam int LAST = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0][N_WAKE-1:0] stage_q;
    logic                              adv;

    generate
        if (SYNC_ON_CORE) begin : g_core_clocked
            // Stages move only on core-clock cycles.
            always_comb adv = core_en;

            // R11: a stopped core clock freezes the request lines.
            a_r11_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
                (!core_en && rst_n) |=> (irq == $past(irq)));
        end else begin : g_free_running
            // Stages move on every reference edge.
            always_comb adv = 1'b1;
        end
    endgenerate

    // Shift the pins through the stages on enabled edges; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (adv) begin
            stage_q[0] <= pin;
            for (int s = 1; s < SYNC_DEPTH; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // The last stage is the request output.
    always_comb irq = stage_q[LAST];

endmodule

// File: rtl/lpm_clk_gate.sv
// Low-power clock enable controller (top).
// Captures status bits, interrupt-in-service and debug enable, then decodes them
// into clock enables; wake pins are synchronized into interrupt requests.
// Assumes: single reference clock; synchronous active-low reset.
module lpm_clk_gate
    import lpm_pkg::*;
#(
    parameter int N_WAKE       = 2,
    parameter int SYNC_DEPTH   = 2,
    parameter bit SUB_GATE_EN  = 1'b1,
    parameter bit AUX_DIV_EN   = 1'b1,
    parameter bit XTAL_OFF_EN  = 1'b1,
    parameter bit SYNC_ON_CORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_off_bit,
    input  logic              fast_osc_off_bit,
    input  logic              sub_clk_off_bit,
    input  logic              xtal_off_bit,
    input  logic              isr_active,
    input  logic              dbg_en,
    input  logic [N_WAKE-1:0] wake_pin,
    output logic              fast_osc_en,
    output logic              core_clk_en,
    output logic              sub_clk_en,
    output logic              aux_clk_en,
    output logic              xtal_en,
    output logic              cpu_halt,
    output logic [N_WAKE-1:0] wake_irq
);

    lpm_state_t st_nxt;
    lpm_state_t st_cur;
    lpm_en_t    en;

    // Bundle the control inputs for capture.
    always_comb begin
        st_nxt.cpu_off  = cpu_off_bit;
        st_nxt.fast_off = fast_osc_off_bit;
        st_nxt.sub_off  = sub_clk_off_bit;
        st_nxt.xtal_off = xtal_off_bit;
        st_nxt.isr      = isr_active;
        st_nxt.dbg      = dbg_en;
    end

    lpm_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (st_nxt),
        .cur   (st_cur)
    );

    lpm_enable_logic #(
        .SUB_GATE_EN (SUB_GATE_EN),
        .AUX_DIV_EN  (AUX_DIV_EN),
        .XTAL_OFF_EN (XTAL_OFF_EN)
    ) u_enables (
        .st (st_cur),
        .en (en)
    );

    lpm_wake_sync #(
        .N_WAKE       (N_WAKE),
        .SYNC_DEPTH   (SYNC_DEPTH),
        .SYNC_ON_CORE (SYNC_ON_CORE)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_en (en.core),
        .pin     (wake_pin),
        .irq     (wake_irq)
    );

    // Drive the enable ports from the decoded bundle.
    always_comb begin
        fast_osc_en = en.fast_osc;
        core_clk_en = en.core;
        sub_clk_en  = en.sub;
        aux_clk_en  = en.aux;
        xtal_en     = en.xtal;
        cpu_halt    = en.halt;
    end

    // R1: leaving reset, the block is fully active with no pending request.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (core_clk_en && fast_osc_en && sub_clk_en && aux_clk_en
                          && xtal_en && !cpu_halt && wake_irq == '0));

    // R3: a captured CPU stop bit halts the CPU unless an interrupt is in service.
    a_r3_halt_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_off_bit && !isr_active) |=> cpu_halt);

    // R7: debug keeps the core clock and fast oscillator alive.
    a_r7_debug_keeps_core: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_en |=> (core_clk_en && fast_osc_en));

    // R8: interrupt service restores every clock and releases the CPU.
    a_r8_isr_restores_all: assert property (@(posedge clk) disable iff (!rst_n)
        isr_active |=> (fast_osc_en && core_clk_en && sub_clk_en && aux_clk_en
                        && xtal_en && !cpu_halt));

    // R2: with the stop bit clear, the core runs from the next edge.
    a_r2_active_core: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_off_bit |=> (core_clk_en && !cpu_halt));

endmodule

// File: tb/lpm_clk_gate_bench.sv
// Bench: a behavioural reference model compared on every clock against two
// builds (all gating options on, and all off with a free synchronizer).
module lpm_clk_gate_bench;

    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_b = 0, fast_b = 0, sub_b = 0, xtal_b = 0, isr = 0, dbg = 0;
    logic [NW-1:0] wake = '0;

    logic f_a, c_a, s_a, a_a, x_a, h_a;
    logic f_b, c_b, s_b, a_b, x_b, h_b;
    logic [NW-1:0] irq_a, irq_b;

    always #2.5 clk = ~clk;

    lpm_clk_gate u_lpm_clk_gate (
        .clk(clk), .rst_n(rst_n), .cpu_off_bit(cpu_b), .fast_osc_off_bit(fast_b),
        .sub_clk_off_bit(sub_b), .xtal_off_bit(xtal_b), .isr_active(isr), .dbg_en(dbg),
        .wake_pin(wake), .fast_osc_en(f_a), .core_clk_en(c_a), .sub_clk_en(s_a),
        .aux_clk_en(a_a), .xtal_en(x_a), .cpu_halt(h_a), .wake_irq(irq_a));

    lpm_clk_gate #(.SUB_GATE_EN(1'b0), .AUX_DIV_EN(1'b0), .XTAL_OFF_EN(1'b0),
                   .SYNC_ON_CORE(1'b0)) u_nogate (
        .clk(clk), .rst_n(rst_n), .cpu_off_bit(cpu_b), .fast_osc_off_bit(fast_b),
        .sub_clk_off_bit(sub_b), .xtal_off_bit(xtal_b), .isr_active(isr), .dbg_en(dbg),
        .wake_pin(wake), .fast_osc_en(f_b), .core_clk_en(c_b), .sub_clk_en(s_b),
        .aux_clk_en(a_b), .xtal_en(x_b), .cpu_halt(h_b), .wake_irq(irq_b));

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string ph = "R1";
    bit    run_checks = 0;

    // Reference model state
    bit m_cpu, m_fast, m_sub, m_xtal, m_isr, m_dbg, m_ce;
    bit [NW-1:0] ms1, ms2, fs1, fs2;

    // Expected {fast, core, sub, aux, xtal, halt} for a given option set.
    function automatic logic [5:0] expect_en(input bit sg, input bit ag, input bit xg);
        bit keep;
        keep = m_isr || m_dbg;
        expect_en[5] = keep || !m_fast;
        expect_en[4] = keep || !m_cpu;
        expect_en[3] = m_isr || !(sg && m_sub);
        expect_en[2] = m_isr || !(ag && xg && m_xtal);
        expect_en[1] = m_isr || !(xg && m_xtal);
        expect_en[0] = m_cpu && !m_isr;
    endfunction

    task automatic check_vec(input string what, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b (fast,core,sub,aux,xtal,halt)",
                     ph, what, got, exp);
        end
    endtask

    task automatic check_irq(input string what, input logic [NW-1:0] got, input logic [NW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s wake_irq: got %b expected %b", ph, what, got, exp);
        end
    endtask

    // Model update at each edge, then compare 1 ns later.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            {m_cpu, m_fast, m_sub, m_xtal, m_isr, m_dbg} = '0;
            ms1 = '0; ms2 = '0; fs1 = '0; fs2 = '0;
        end else begin
            m_ce = m_isr || m_dbg || !m_cpu;
            if (m_ce) begin ms2 = ms1; ms1 = wake; end
            fs2 = fs1; fs1 = wake;
            m_cpu = cpu_b; m_fast = fast_b; m_sub = sub_b; m_xtal = xtal_b;
            m_isr = isr; m_dbg = dbg;
        end
        #1;
        if (run_checks) begin
            check_vec("gated", {f_a, c_a, s_a, a_a, x_a, h_a}, expect_en(1, 1, 1));
            check_vec("ungated", {f_b, c_b, s_b, a_b, x_b, h_b}, expect_en(0, 0, 0));
            check_irq("core-sync", irq_a, ms2);
            check_irq("free-sync", irq_b, fs2);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bits ordered cpu, fast, sub, xtal.
    task automatic set_level(input logic [3:0] b);
        @(negedge clk);
        {cpu_b, fast_b, sub_b, xtal_b} = b;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        step(2);
        run_checks = 1;                 // R1 reset state checked while held
        step(2);
        rst_n = 1'b1;
        step(3);

        ph = "R2"; set_level(4'b1000); step(3);     // level 0, one-edge latency
        ph = "R3"; step(2);
        ph = "R4"; set_level(4'b1100); step(4);     // level 1
        ph = "R5"; set_level(4'b1010); step(4);     // level 2
        set_level(4'b1110); step(4);                // level 3
        ph = "R6"; set_level(4'b1111); step(4);     // level 4
        ph = "R7"; @(negedge clk) dbg = 1; step(4);
        set_level(4'b1000); step(3);
        @(negedge clk) dbg = 0;
        ph = "R8"; set_level(4'b1110); step(2);
        @(negedge clk) isr = 1; step(4);
        ph = "R9"; @(negedge clk) isr = 0; step(4); // bits intact: level 3 again
        @(negedge clk) isr = 1; step(2);
        set_level(4'b0000); step(2);                // bits cleared during service
        @(negedge clk) isr = 0; step(4);

        ph = "R10"; @(negedge clk) wake[0] = 1; step(5);
        @(negedge clk) wake[0] = 0; step(4);

        ph = "R11"; set_level(4'b1000); step(2);    // core stopped, no debug
        @(negedge clk) wake[1] = 1; step(6);
        @(negedge clk) isr = 1; step(4);            // core restarts, request emerges
        @(negedge clk) isr = 0; wake[1] = 0; step(5);
        @(negedge clk) isr = 1; step(4);
        @(negedge clk) isr = 0; step(2);

        ph = "R1"; @(negedge clk) rst_n = 0; wake = 2'b11; step(3);
        @(negedge clk) rst_n = 1; step(2);
        @(negedge clk) wake = '0; set_level(4'b0000); step(4);

        finish_run();
    end

endmodule